// File: doc/BRIEF.md
# Three-Level Switching Sequence Generator

This block drives the three phase legs of a three-level neutral-clamped inverter. A region selector upstream supplies the sector in which the reference vector lies, a code for the triangle inside that sector, and three dwell times. These dwell times are given in clock ticks and belong to the three vertices of the triangle. The generator runs a free counter that closes one switching period every `CLK_HZ / SW_HZ` clocks. At each period boundary it captures the inputs. It then walks through an ordered list of space-vector states for that period.

Region code 0 is the nearest-triangle case that contains a medium vector. Codes 1 to 4 are the balancing triangles. These use only short and large vectors, so no medium state is ever driven for them. Each short vector can be made by two redundant states. Its dwell is split between them, so the neutral point sees equal charge in both directions.

The state lists are written once for the first sector. The lists for the other five sectors are derived by rotating through 60 degrees. Any step in which a leg would swing straight from +1 to -1 inside a period is refused. The legs then hold their previous state and an error flag is raised.

Top module: `tl_seq_gen`

## Requirements
- R1: Each leg output uses 2'b01 for +1, 2'b00 for 0 and 2'b10 for -1. The code 2'b11 never appears.
- R2: `period_start_o` is a one-cycle pulse every PERIOD = CLK_HZ/SW_HZ clocks. It is high in the cycle whose leg outputs show tick 0 of a period. Tick t of a period is shown t clocks after the pulse.
- R3: Sector, region, duties and the decision to run are taken only at the period boundary. Changing them inside a period leaves the remainder of that period unchanged.
- R4: Sector 0, region 0 (duties A = short (1,0,0)/(0,-1,-1), B = short (1,1,0)/(0,0,-1), C = medium (1,0,-1)) plays the following slots, in this order:
  - (1,1,0) for B lead
  - (1,0,-1) for C lead
  - (1,0,0) for A lead
  - (0,0,-1) for B trail
  - (1,0,-1) for C trail
  - (0,-1,-1) for A trail
- R5: Sector 0, regions 1 to 4 use only short and large states. The duties are A, B, C as listed per region:
  - Region 1 (A short 1, B large (1,-1,-1), C short 2): (0,0,-1) C lead, (0,-1,-1) A lead, (1,-1,-1) B, (1,0,0) A trail, (1,1,0) C trail.
  - Region 2 (A short 1, B large (1,-1,-1), C large (1,1,-1)): (0,-1,-1) A lead, (1,-1,-1) B, (1,0,0) A trail, (1,1,-1) C.
  - Region 3 (A short 2, B (1,-1,-1), C (1,1,-1)): (1,-1,-1) B, (0,0,-1) A lead, (1,1,-1) C, (1,1,0) A trail.
  - Region 4 (A short 1, B short 2, C (1,1,-1)): (0,-1,-1) A lead, (0,0,-1) B lead, (1,1,-1) C, (1,0,0) A trail, (1,1,0) B trail.
- R6: A short or medium dwell d is split into a lead part of floor(d/2) ticks and a trail part of d - floor(d/2) ticks. A large dwell plays as one part of d ticks.
- R7: In sector k (0 to 5), every state is the sector-0 state turned k times by the map (a,b,c) -> (-b,-c,-a).
- R8: Zero-length parts are skipped. Ticks past the sum of all parts keep the last state driven.
- R9: Inside a period, a step that would move any leg between +1 and -1 is refused. The legs keep their state and `seq_err_o` goes high from that tick until the next period start, where it reads 0.
- R10: With `enable_i` low, all legs read 0 from the next clock. Raising `enable_i` again takes effect only at the next period boundary.
- R11: A captured sector of 6 or 7, or a region above 4, gives all-zero legs for that period with `seq_err_o` low.
- R12: During and right after reset, legs, `seq_err_o` and `period_start_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; low forces all legs to 0 |
| sector_i | input | 3 | Sector 0 to 5 |
| region_i | input | 3 | Triangle code 0 to 4 within the sector |
| duty_a_i | input | DW | Dwell of vertex A in ticks |
| duty_b_i | input | DW | Dwell of vertex B in ticks |
| duty_c_i | input | DW | Dwell of vertex C in ticks |
| leg_a_o | output | 2 | Phase A leg state |
| leg_b_o | output | 2 | Phase B leg state |
| leg_c_o | output | 2 | Phase C leg state |
| period_start_o | output | 1 | Pulse marking tick 0 of each period |
| seq_err_o | output | 1 | A refused full-swing step occurred this period |

## Verification
The bench builds the block with CLK_HZ = 1000 and SW_HZ = 10, which gives a 100-tick period. This short period lets every tick of every observed period be compared against an independent model of the slot list, the sector rotation and the hold-on-refusal rule. Duties in the 0 to 50 range reach the corner cases:
- odd splits;
- zero-length short parts that expose a full swing between the two large states;
- unused tail ticks.

The default 20000-tick period is only elaborated.

// File: rtl/tl_seq_pkg.sv
package tl_seq_pkg;

  localparam int NSLOT = 6;
  localparam int NSECT = 6;
  localparam int NREGION = 5;

  typedef logic [1:0] leg_t;
  localparam leg_t LEG_POS  = 2'b01;
  localparam leg_t LEG_ZERO = 2'b00;
  localparam leg_t LEG_NEG  = 2'b10;

  typedef struct packed {
    leg_t a;
    leg_t b;
    leg_t c;
  } vec_t;

  typedef enum logic [1:0] {
    PART_NONE  = 2'd0,
    PART_FULL  = 2'd1,
    PART_LEAD  = 2'd2,
    PART_TRAIL = 2'd3
  } part_e;

  typedef struct packed {
    vec_t       st;
    logic [1:0] dsel;
    part_e      part;
  } slot_t;

  // sector-0 states
  localparam vec_t ST_SA_P = {LEG_POS,  LEG_ZERO, LEG_ZERO};
  localparam vec_t ST_SA_N = {LEG_ZERO, LEG_NEG,  LEG_NEG};
  localparam vec_t ST_SB_P = {LEG_POS,  LEG_POS,  LEG_ZERO};
  localparam vec_t ST_SB_N = {LEG_ZERO, LEG_ZERO, LEG_NEG};
  localparam vec_t ST_MID  = {LEG_POS,  LEG_ZERO, LEG_NEG};
  localparam vec_t ST_LG_0 = {LEG_POS,  LEG_NEG,  LEG_NEG};
  localparam vec_t ST_LG_1 = {LEG_POS,  LEG_POS,  LEG_NEG};
  localparam vec_t ST_IDLE = {LEG_ZERO, LEG_ZERO, LEG_ZERO};

  function automatic leg_t leg_flip(leg_t l);
    case (l)
      LEG_POS: leg_flip = LEG_NEG;
      LEG_NEG: leg_flip = LEG_POS;
      default: leg_flip = LEG_ZERO;
    endcase
  endfunction

  // one 60-degree step: (a,b,c) -> (-b,-c,-a)
  function automatic vec_t rot60(vec_t v);
    rot60 = {leg_flip(v.b), leg_flip(v.c), leg_flip(v.a)};
  endfunction

  function automatic vec_t rot_sector(vec_t v, logic [2:0] sec);
    vec_t r;
    r = v;
    for (int i = 0; i < NSECT - 1; i++) begin
      if (3'(i) < sec) r = rot60(r);
    end
    rot_sector = r;
  endfunction

  function automatic logic leg_swing(leg_t x, leg_t y);
    leg_swing = ((x == LEG_POS) && (y == LEG_NEG)) ||
                ((x == LEG_NEG) && (y == LEG_POS));
  endfunction

  function automatic logic vec_swing(vec_t x, vec_t y);
    vec_swing = leg_swing(x.a, y.a) | leg_swing(x.b, y.b) | leg_swing(x.c, y.c);
  endfunction

  function automatic slot_t mk_slot(vec_t st, logic [1:0] dsel, part_e part);
    mk_slot = {st, dsel, part};
  endfunction

  // sector-0 slot list; dsel 0/1/2 selects duty A/B/C
  function automatic slot_t base_slot(logic [2:0] region, logic [2:0] idx);
    slot_t s;
    s = mk_slot(ST_IDLE, 2'd0, PART_NONE);
    case (region)
      3'd0: case (idx)
        3'd0: s = mk_slot(ST_SB_P, 2'd1, PART_LEAD);
        3'd1: s = mk_slot(ST_MID,  2'd2, PART_LEAD);
        3'd2: s = mk_slot(ST_SA_P, 2'd0, PART_LEAD);
        3'd3: s = mk_slot(ST_SB_N, 2'd1, PART_TRAIL);
        3'd4: s = mk_slot(ST_MID,  2'd2, PART_TRAIL);
        3'd5: s = mk_slot(ST_SA_N, 2'd0, PART_TRAIL);
        default: ;
      endcase
      3'd1: case (idx)
        3'd0: s = mk_slot(ST_SB_N, 2'd2, PART_LEAD);
        3'd1: s = mk_slot(ST_SA_N, 2'd0, PART_LEAD);
        3'd2: s = mk_slot(ST_LG_0, 2'd1, PART_FULL);
        3'd3: s = mk_slot(ST_SA_P, 2'd0, PART_TRAIL);
        3'd4: s = mk_slot(ST_SB_P, 2'd2, PART_TRAIL);
        default: ;
      endcase
      3'd2: case (idx)
        3'd0: s = mk_slot(ST_SA_N, 2'd0, PART_LEAD);
        3'd1: s = mk_slot(ST_LG_0, 2'd1, PART_FULL);
        3'd2: s = mk_slot(ST_SA_P, 2'd0, PART_TRAIL);
        3'd3: s = mk_slot(ST_LG_1, 2'd2, PART_FULL);
        default: ;
      endcase
      3'd3: case (idx)
        3'd0: s = mk_slot(ST_LG_0, 2'd1, PART_FULL);
        3'd1: s = mk_slot(ST_SB_N, 2'd0, PART_LEAD);
        3'd2: s = mk_slot(ST_LG_1, 2'd2, PART_FULL);
        3'd3: s = mk_slot(ST_SB_P, 2'd0, PART_TRAIL);
        default: ;
      endcase
      3'd4: case (idx)
        3'd0: s = mk_slot(ST_SA_N, 2'd0, PART_LEAD);
        3'd1: s = mk_slot(ST_SB_N, 2'd1, PART_LEAD);
        3'd2: s = mk_slot(ST_LG_1, 2'd2, PART_FULL);
        3'd3: s = mk_slot(ST_SA_P, 2'd0, PART_TRAIL);
        3'd4: s = mk_slot(ST_SB_P, 2'd1, PART_TRAIL);
        default: ;
      endcase
      default: ;
    endcase
    base_slot = s;
  endfunction

endpackage

// File: rtl/tl_seq_table.sv
module tl_seq_table
  import tl_seq_pkg::*;
(
  input  logic [2:0]              sector_i,
  input  logic [2:0]              region_i,
  output slot_t [NSLOT-1:0]       slots_o,
  output logic                    valid_o
);

  assign valid_o = (sector_i < 3'(NSECT)) && (region_i < 3'(NREGION));

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    slot_t base;
    always_comb begin
      base = base_slot(region_i, 3'(g));
      slots_o[g] = {rot_sector(base.st, sector_i), base.dsel, base.part};
    end
  end

endmodule

// File: rtl/tl_seq_timer.sv
module tl_seq_timer #(
  parameter int PERIOD = 100,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          tick0_o,
  output logic          pstart_o
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          pstart_q;

  assign wrap_o  = (cnt_q == LAST);
  assign tick0_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= LAST;
      pstart_q <= 1'b0;
    end else begin
      cnt_q    <= wrap_o ? '0 : cnt_q + 1'b1;
      pstart_q <= tick0_o;
    end
  end

  assign cnt_o    = cnt_q;
  assign pstart_o = pstart_q;

endmodule

// File: rtl/tl_seq_slots.sv
module tl_seq_slots
  import tl_seq_pkg::*;
#(
  parameter int CW = 7,
  parameter int DW = 7,
  localparam int EW = DW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  slot_t [NSLOT-1:0] slots_i,
  input  logic [DW-1:0]     duty_a_i,
  input  logic [DW-1:0]     duty_b_i,
  input  logic [DW-1:0]     duty_c_i,
  input  logic [CW-1:0]     cnt_i,
  output logic              hit_o,
  output vec_t              cand_o
);

  function automatic logic [DW-1:0] pick_duty(logic [1:0] s, logic [DW-1:0] a,
                                              logic [DW-1:0] b, logic [DW-1:0] c);
    case (s)
      2'd0:    pick_duty = a;
      2'd1:    pick_duty = b;
      2'd2:    pick_duty = c;
      default: pick_duty = '0;
    endcase
  endfunction

  // lead part floor(d/2), trail part the rest, so the two always sum to d
  function automatic logic [EW-1:0] part_len(part_e p, logic [DW-1:0] d);
    logic [EW-1:0] dw;
    dw = EW'(d);
    case (p)
      PART_FULL:  part_len = dw;
      PART_LEAD:  part_len = dw >> 1;
      PART_TRAIL: part_len = dw - (dw >> 1);
      default:    part_len = '0;
    endcase
  endfunction

  logic [NSLOT-1:0][EW-1:0] end_d, end_q;
  vec_t [NSLOT-1:0]         st_q;

  always_comb begin
    logic [EW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NSLOT; i++) begin
      acc = acc + part_len(slots_i[i].part,
                           pick_duty(slots_i[i].dsel, duty_a_i, duty_b_i, duty_c_i));
      end_d[i] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q <= '0;
      st_q  <= '0;
    end else if (load_i) begin
      end_q <= end_d;
      for (int i = 0; i < NSLOT; i++) st_q[i] <= slots_i[i].st;
    end
  end

  // lowest slot whose end lies beyond the current tick
  always_comb begin
    hit_o  = 1'b0;
    cand_o = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (EW'(cnt_i) < end_q[i]) begin
        hit_o  = 1'b1;
        cand_o = st_q[i];
      end
    end
  end

endmodule

// File: rtl/tl_seq_gen.sv
module tl_seq_gen
  import tl_seq_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int SW_HZ  = 5000,
  localparam int PERIOD = CLK_HZ / SW_HZ,
  localparam int CW     = $clog2(PERIOD),
  localparam int DW     = $clog2(PERIOD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [2:0]    sector_i,
  input  logic [2:0]    region_i,
  input  logic [DW-1:0] duty_a_i,
  input  logic [DW-1:0] duty_b_i,
  input  logic [DW-1:0] duty_c_i,
  output logic [1:0]    leg_a_o,
  output logic [1:0]    leg_b_o,
  output logic [1:0]    leg_c_o,
  output logic          period_start_o,
  output logic          seq_err_o
);

  logic [CW-1:0]     cnt;
  logic              wrap, tick0;
  slot_t [NSLOT-1:0] slots;
  logic              cfg_valid;
  logic              hit;
  vec_t              cand;

  logic run_q, err_q;
  vec_t legs_q;

  tl_seq_timer #(.PERIOD(PERIOD)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_o   (cnt),
    .wrap_o  (wrap),
    .tick0_o (tick0),
    .pstart_o(period_start_o)
  );

  tl_seq_table u_table (
    .sector_i(sector_i),
    .region_i(region_i),
    .slots_o (slots),
    .valid_o (cfg_valid)
  );

  tl_seq_slots #(.CW(CW), .DW(DW)) u_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wrap),
    .slots_i (slots),
    .duty_a_i(duty_a_i),
    .duty_b_i(duty_b_i),
    .duty_c_i(duty_c_i),
    .cnt_i   (cnt),
    .hit_o   (hit),
    .cand_o  (cand)
  );

  // named events
  wire live        = run_q & enable_i;
  wire step_reject = live & ~tick0 & hit & vec_swing(legs_q, cand);
  wire step_take   = live & hit & (tick0 | ~vec_swing(legs_q, cand));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      err_q  <= 1'b0;
      legs_q <= ST_IDLE;
    end else begin
      run_q <= wrap ? (enable_i & cfg_valid) : (run_q & enable_i);
      if (!live) begin
        legs_q <= ST_IDLE;
        err_q  <= 1'b0;
      end else begin
        if (step_take) legs_q <= cand;
        if (tick0)            err_q <= 1'b0;
        else if (step_reject) err_q <= 1'b1;
      end
    end
  end

  assign leg_a_o   = legs_q.a;
  assign leg_b_o   = legs_q.b;
  assign leg_c_o   = legs_q.c;
  assign seq_err_o = err_q;

endmodule

// File: rtl/tl_seq_gen_chk.sv
module tl_seq_gen_chk #(
  parameter int PERIOD = 100
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic [1:0] leg_a_o,
  input logic [1:0] leg_b_o,
  input logic [1:0] leg_c_o,
  input logic       period_start_o,
  input logic       seq_err_o
);

  localparam int GW = $clog2(PERIOD) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= period_start_o ? '0 : gap_q + 1'b1;
      if (period_start_o) seen_q <= 1'b1;
    end
  end

  function automatic logic swing(logic [1:0] x, logic [1:0] y);
    swing = ((x == 2'b01) && (y == 2'b10)) || ((x == 2'b10) && (y == 2'b01));
  endfunction

  AST_LEG_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leg_a_o != 2'b11) && (leg_b_o != 2'b11) && (leg_c_o != 2'b11)); // R1

  AST_PERIOD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_o && seen_q) |-> (gap_q == GW'(PERIOD - 1))); // R2

  AST_NO_FULL_SWING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_o |-> !(swing($past(leg_a_o), leg_a_o) || swing($past(leg_b_o), leg_b_o)
                         || swing($past(leg_c_o), leg_c_o))); // R9

  AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(seq_err_o) && !period_start_o) |->
      ($stable(leg_a_o) && $stable(leg_b_o) && $stable(leg_c_o))); // R9

  AST_ERR_CLEAR_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> !seq_err_o); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> ((leg_a_o == 2'b00) && (leg_b_o == 2'b00) && (leg_c_o == 2'b00)
                   && !seq_err_o)); // R10

endmodule

bind tl_seq_gen tl_seq_gen_chk #(.PERIOD(PERIOD)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .leg_a_o       (leg_a_o),
  .leg_b_o       (leg_b_o),
  .leg_c_o       (leg_c_o),
  .period_start_o(period_start_o),
  .seq_err_o     (seq_err_o)
);

// File: tb/tl_seq_gen_test.sv
module tl_seq_gen_test;

  localparam int CLK_HZ = 1000;
  localparam int SW_HZ  = 10;
  localparam int P      = CLK_HZ / SW_HZ;
  localparam int DW     = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable_i = 1'b0;
  logic [2:0]    sector_i = '0;
  logic [2:0]    region_i = '0;
  logic [DW-1:0] duty_a_i = '0, duty_b_i = '0, duty_c_i = '0;
  logic [1:0]    leg_a_o, leg_b_o, leg_c_o;
  logic          period_start_o, seq_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tl_seq_gen #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable_i),
    .sector_i(sector_i), .region_i(region_i),
    .duty_a_i(duty_a_i), .duty_b_i(duty_b_i), .duty_c_i(duty_c_i),
    .leg_a_o(leg_a_o), .leg_b_o(leg_b_o), .leg_c_o(leg_c_o),
    .period_start_o(period_start_o), .seq_err_o(seq_err_o)
  );

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [1:0] enc(int v);
    return (v > 0) ? 2'b01 : (v < 0) ? 2'b10 : 2'b00;
  endfunction

  // sector-0 slot list restated: part 0 none, 1 whole, 2 lead, 3 trail
  function automatic void base(input int rg, input int ix, output int a, output int b,
                               output int c, output int sel, output int pt);
    a = 0; b = 0; c = 0; sel = 0; pt = 0;
    case (rg * 10 + ix)
      0:  begin a = 1; b = 1; c = 0;   sel = 1; pt = 2; end
      1:  begin a = 1; b = 0; c = -1;  sel = 2; pt = 2; end
      2:  begin a = 1; b = 0; c = 0;   sel = 0; pt = 2; end
      3:  begin a = 0; b = 0; c = -1;  sel = 1; pt = 3; end
      4:  begin a = 1; b = 0; c = -1;  sel = 2; pt = 3; end
      5:  begin a = 0; b = -1; c = -1; sel = 0; pt = 3; end
      10: begin a = 0; b = 0; c = -1;  sel = 2; pt = 2; end
      11: begin a = 0; b = -1; c = -1; sel = 0; pt = 2; end
      12: begin a = 1; b = -1; c = -1; sel = 1; pt = 1; end
      13: begin a = 1; b = 0; c = 0;   sel = 0; pt = 3; end
      14: begin a = 1; b = 1; c = 0;   sel = 2; pt = 3; end
      20: begin a = 0; b = -1; c = -1; sel = 0; pt = 2; end
      21: begin a = 1; b = -1; c = -1; sel = 1; pt = 1; end
      22: begin a = 1; b = 0; c = 0;   sel = 0; pt = 3; end
      23: begin a = 1; b = 1; c = -1;  sel = 2; pt = 1; end
      30: begin a = 1; b = -1; c = -1; sel = 1; pt = 1; end
      31: begin a = 0; b = 0; c = -1;  sel = 0; pt = 2; end
      32: begin a = 1; b = 1; c = -1;  sel = 2; pt = 1; end
      33: begin a = 1; b = 1; c = 0;   sel = 0; pt = 3; end
      40: begin a = 0; b = -1; c = -1; sel = 0; pt = 2; end
      41: begin a = 0; b = 0; c = -1;  sel = 1; pt = 2; end
      42: begin a = 1; b = 1; c = -1;  sel = 2; pt = 1; end
      43: begin a = 1; b = 0; c = 0;   sel = 0; pt = 3; end
      44: begin a = 1; b = 1; c = 0;   sel = 1; pt = 3; end
      default: ;
    endcase
  endfunction

  // 120-degree steps are a cyclic shift; an odd sector adds one negating step
  function automatic void rotate(input int k, inout int a, inout int b, inout int c);
    int t;
    for (int i = 0; i < k / 2; i++) begin
      t = c; c = b; b = a; a = t;
    end
    if (k % 2 == 1) begin
      t = a; a = -b; b = -c; c = -t;
    end
  endfunction

  function automatic bit jumps(int x, int y);
    return (x * y) == -1;
  endfunction

  task automatic drive(input int sec, input int rg, input int da, input int db,
                       input int dc, input bit en);
    sector_i = 3'(sec); region_i = 3'(rg);
    duty_a_i = DW'(da); duty_b_i = DW'(db); duty_c_i = DW'(dc);
    enable_i = en;
  endtask

  task automatic wait_pstart;
    @(negedge clk);
    while (!period_start_o) @(negedge clk);
  endtask

  // called at the negedge where period_start_o is high; checks all P ticks
  task automatic compare_period(input int sec, input int rg, input int da, input int db,
                                input int dc, input bit en, input string req,
                                input bit disturb);
    int sa[6], sb[6], sc[6], ln[6];
    int ca = 0, cb = 0, cc = 0;
    bit er = 1'b0;
    bit run;
    int bad = 0;
    string msg = "";
    run = en && sec < 6 && rg < 5;
    for (int i = 0; i < 6; i++) begin
      int a, b, c, sel, pt, d;
      base(rg, i, a, b, c, sel, pt);
      rotate(sec, a, b, c);
      sa[i] = a; sb[i] = b; sc[i] = c;
      d = (sel == 0) ? da : (sel == 1) ? db : dc;
      ln[i] = (pt == 1) ? d : (pt == 2) ? d / 2 : (pt == 3) ? d - d / 2 : 0;
      if (!run) ln[i] = 0;
    end
    for (int t = 0; t < P; t++) begin
      int acc = 0;
      bit hit = 1'b0;
      int na = 0, nb = 0, nc = 0;
      if (t > 0) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
        if (!hit && t < acc + ln[i]) begin
          hit = 1'b1; na = sa[i]; nb = sb[i]; nc = sc[i];
        end
        acc += ln[i];
      end
      if (!run) begin
        ca = 0; cb = 0; cc = 0; er = 1'b0;
      end else if (t == 0) begin
        if (hit) begin ca = na; cb = nb; cc = nc; end
        er = 1'b0;
      end else if (hit) begin
        if (jumps(ca, na) || jumps(cb, nb) || jumps(cc, nc)) er = 1'b1;
        else begin ca = na; cb = nb; cc = nc; end
      end
      if (leg_a_o == 2'b11 || leg_b_o == 2'b11 || leg_c_o == 2'b11) begin
        if (bad == 0) msg = $sformatf("R1 illegal code at tick %0d", t);
        bad++;
      end else if (leg_a_o !== enc(ca) || leg_b_o !== enc(cb) || leg_c_o !== enc(cc)
                   || seq_err_o !== er || period_start_o !== (t == 0)) begin
        if (bad == 0)
          msg = $sformatf("tick %0d actual legs %b %b %b err %b ps %b expected %b %b %b err %b ps %b",
                          t, leg_a_o, leg_b_o, leg_c_o, seq_err_o, period_start_o,
                          enc(ca), enc(cb), enc(cc), er, t == 0);
        bad++;
      end
      if (disturb && t == P / 2) drive(4, 3, 7, 9, 11, 1'b1);
    end
    check(bad == 0, req, msg);
  endtask

  task automatic check_period(input int sec, input int rg, input int da, input int db,
                              input int dc, input bit en, input string req);
    drive(sec, rg, da, db, dc, en);
    wait_pstart;
    wait_pstart;
    compare_period(sec, rg, da, db, dc, en, req, 1'b0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(leg_a_o == 2'b00 && leg_b_o == 2'b00 && leg_c_o == 2'b00 && !seq_err_o
          && !period_start_o, "R12", $sformatf("in reset actual %b%b%b err %b ps %b expected 000000 0 0",
          leg_a_o, leg_b_o, leg_c_o, seq_err_o, period_start_o));
    rst_n = 1'b1;
    @(negedge clk);
    check(leg_a_o == 2'b00 && leg_b_o == 2'b00 && leg_c_o == 2'b00 && !seq_err_o
          && !period_start_o, "R12", $sformatf("after reset actual %b%b%b err %b ps %b expected 000000 0 0",
          leg_a_o, leg_b_o, leg_c_o, seq_err_o, period_start_o));
  endtask

  task automatic t_period_pulse;
    int gap = 0;
    wait_pstart;
    @(negedge clk);
    check(!period_start_o, "R2", $sformatf("pulse width actual %b expected 0", period_start_o));
    gap = 1;
    while (!period_start_o) begin
      @(negedge clk);
      gap++;
    end
    check(gap == P, "R2", $sformatf("pulse spacing actual %0d expected %0d", gap, P));
  endtask

  task automatic t_nearest;
    check_period(0, 0, 20, 30, 40, 1'b1, "R4 nearest order, R8 tail hold");
    check_period(0, 0, 21, 33, 45, 1'b1, "R6 odd split");
    check_period(0, 0, 30, 30, 0, 1'b1, "R8 medium skipped");
  endtask

  task automatic t_selected;
    check_period(0, 1, 20, 30, 40, 1'b1, "R5 region1");
    check_period(0, 2, 20, 30, 40, 1'b1, "R5 region2");
    check_period(0, 3, 21, 30, 40, 1'b1, "R5 region3");
    check_period(0, 4, 20, 31, 40, 1'b1, "R5 region4");
  endtask

  task automatic t_sectors;
    for (int s = 1; s < 6; s++)
      check_period(s, (s % 2 == 1) ? 1 : 4, 20 + s, 30, 40, 1'b1,
                   $sformatf("R7 sector %0d", s));
  endtask

  task automatic t_reject;
    check_period(0, 2, 0, 40, 50, 1'b1, "R9 region2 reject");
    wait_pstart;
    compare_period(0, 2, 0, 40, 50, 1'b1, "R9 err clears at start", 1'b0);
    check_period(3, 3, 0, 30, 30, 1'b1, "R9 rotated region3 reject");
  endtask

  task automatic t_midchange;
    drive(0, 1, 20, 30, 40, 1'b1);
    wait_pstart;
    wait_pstart;
    compare_period(0, 1, 20, 30, 40, 1'b1, "R3 mid-period change ignored", 1'b1);
    wait_pstart;
    compare_period(4, 3, 7, 9, 11, 1'b1, "R3 change taken at boundary", 1'b0);
  endtask

  task automatic t_enable;
    int bad = 0;
    check_period(0, 1, 20, 30, 40, 1'b0, "R10 disabled period");
    drive(0, 1, 20, 30, 40, 1'b1);
    wait_pstart;
    wait_pstart;
    repeat (30) @(negedge clk);
    enable_i = 1'b0;
    @(negedge clk);
    check(leg_a_o == 2'b00 && leg_b_o == 2'b00 && leg_c_o == 2'b00,
          "R10", $sformatf("drop actual %b%b%b expected 000000", leg_a_o, leg_b_o, leg_c_o));
    repeat (29) @(negedge clk);
    enable_i = 1'b1;
    for (int t = 61; t < P; t++) begin
      @(negedge clk);
      if (leg_a_o != 2'b00 || leg_b_o != 2'b00 || leg_c_o != 2'b00) bad++;
    end
    check(bad == 0, "R10", $sformatf("re-enable mid-period actual %0d nonzero ticks expected 0", bad));
    wait_pstart;
    compare_period(0, 1, 20, 30, 40, 1'b1, "R10 resumes at boundary", 1'b0);
  endtask

  task automatic t_invalid;
    check_period(6, 1, 20, 30, 40, 1'b1, "R11 sector 6");
    check_period(2, 5, 20, 30, 40, 1'b1, "R11 region 5");
  endtask

  initial begin
    t_reset;
    t_period_pulse;
    t_nearest;
    t_selected;
    t_sectors;
    t_reject;
    t_midchange;
    t_enable;
    t_invalid;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule